// File: doc/BRIEF.md
# Machine Status Register Update Unit

This block holds a processor's 32-bit machine status word and applies the special updates that instructions make to it. These updates are carry writes, bit-mask set and clear, whole-word loads, and the three mode-restoring returns: from interrupt, from break and from exception. A return does not act when it is issued. It is armed, and it takes effect in the cycle that the delay-slot instruction completes, which is signalled on `slot_done_i`.

The unit also enforces privilege. When the caller is in user mode and exceptions are enabled, a privileged operation leaves the register untouched and produces a one-cycle fault strobe. The privileged operations are all returns, whole-word loads, and set or clear with a mask other than 0 or 4. The current carry is always available on its own output.

Top module: `msr_unit`

## Requirements
- R1: After reset, `msr_o` is all zeros, `carry_o` is 0 and `priv_fault_o` is 0. Any armed return is discarded.
- R2: Op code 1 (carry write) copies `operand_i[0]` into bit 31 (carry) and bit 2 (carry copy) and leaves every other bit unchanged. `carry_o` always equals bit 31. The new value is visible one clock edge after the op is sampled.
- R3: Op code 2 (set bits) ORs `operand_i` into the register. `msr_o` shows the old value up to that edge.
- R4: Op code 3 (clear bits) ANDs the register with the inverse of `operand_i`.
- R5: Op code 4 (whole load) loads `operand_i` with bit 10 forced to 1.
- R6: Op code 5 (return from interrupt), at commit, sets bit 1 (interrupt enable). It then copies bit 12 into bit 11 (user mode) and bit 14 into bit 13 (virtual mode).
- R7: Op code 6 (return from break), at commit, clears bit 3 (break in progress) and then restores bits 11 and 13 from bits 12 and 14.
- R8: Op code 7 (return from exception), at commit, sets bit 8 (exception enable), clears bit 9 (exception in progress), and then restores bits 11 and 13 from bits 12 and 14.
- R9: A return changes nothing at its own edge. Its effect is applied at the first later edge where `slot_done_i` is 1. `slot_done_i` with nothing armed has no effect.
- R10: With `user_i`=1 and `exc_en_i`=1, the following ops raise `priv_fault_o` for one cycle after the op, leave the register unchanged and arm nothing: op codes 4 to 7, and op codes 2 and 3 with an operand other than 0 or 4.
- R11: Set and clear with operand 0 or 4 are allowed in user mode. With `exc_en_i`=0, no op faults.
- R12: When `slot_done_i` commits a return in the same cycle as another op, that op is applied first. The restore then acts on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0 none, 1 carry, 2 set, 3 clear, 4 load, 5/6/7 returns) |
| operand_i | input | XLEN | Operand, carry value in bit 0 |
| user_i | input | 1 | Caller is in user mode |
| exc_en_i | input | 1 | Exceptions are enabled |
| slot_done_i | input | 1 | Delay-slot instruction completes this cycle |
| msr_o | output | XLEN | Status register value |
| carry_o | output | 1 | Current carry (bit 31) |
| priv_fault_o | output | 1 | Privileged-instruction fault strobe |

## Verification
The delay-slot commit of an armed return and the slot instruction's own update can fall in the same clock edge. The bench provokes this in two ways. First, it arms a return and then presents a clear of the saved user-mode bit together with `slot_done_i`. Second, it arms a return and then presents a carry write together with `slot_done_i`. It judges each case by comparing the resulting word against a value worked out with the slot update applied first and the restore second. A wrong order shows as a different user-mode bit or a lost carry.

// File: rtl/msr_pkg.sv
package msr_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_CARRY   = 3'd1,
    OP_SET     = 3'd2,
    OP_CLR     = 3'd3,
    OP_LOAD    = 3'd4,
    OP_RET_INT = 3'd5,
    OP_RET_BRK = 3'd6,
    OP_RET_EXC = 3'd7
  } msr_op_e;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_INT  = 2'd1,
    RK_BRK  = 2'd2,
    RK_EXC  = 2'd3
  } ret_kind_e;

  localparam int unsigned POS_IE    = 1;
  localparam int unsigned POS_CCOPY = 2;
  localparam int unsigned POS_BIP   = 3;
  localparam int unsigned POS_EE    = 8;
  localparam int unsigned POS_EIP   = 9;
  localparam int unsigned POS_VER   = 10;
  localparam int unsigned POS_UM    = 11;
  localparam int unsigned POS_VM    = 13;
  localparam int unsigned POS_CARRY = 31;
  localparam int unsigned NUM_MODE  = 2;

  function automatic int unsigned mode_pos(int unsigned k);
    return (k == 0) ? POS_UM : POS_VM;
  endfunction
endpackage

// File: rtl/msr_priv_check.sv
module msr_priv_check
  import msr_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned SAFE_A = 0,
  parameter int unsigned SAFE_B = 4
) (
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] operand_i,
  input  logic            user_i,
  input  logic            exc_en_i,
  output logic            fault_o
);
  logic mask_safe;
  logic priv_op;

  always_comb begin
    mask_safe = (operand_i == XLEN'(SAFE_A)) || (operand_i == XLEN'(SAFE_B));
    unique case (msr_op_e'(op_i))
      OP_SET, OP_CLR:                       priv_op = !mask_safe;
      OP_LOAD, OP_RET_INT, OP_RET_BRK,
      OP_RET_EXC:                           priv_op = 1'b1;
      default:                              priv_op = 1'b0;
    endcase
    fault_o = user_i && exc_en_i && priv_op;
  end
endmodule

// File: rtl/msr_op_unit.sv
module msr_op_unit
  import msr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] msr_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] operand_i,
  input  logic            accept_i,
  output logic [XLEN-1:0] msr_o
);
  always_comb begin
    msr_o = msr_i;
    if (accept_i) begin
      unique case (msr_op_e'(op_i))
        OP_CARRY: begin
          msr_o[POS_CARRY] = operand_i[0];
          msr_o[POS_CCOPY] = operand_i[0];
        end
        OP_SET:  msr_o = msr_i | operand_i;
        OP_CLR:  msr_o = msr_i & ~operand_i;
        OP_LOAD: begin
          msr_o = operand_i;
          msr_o[POS_VER] = 1'b1;
        end
        default: msr_o = msr_i;
      endcase
    end
  end
endmodule

// File: rtl/msr_restore.sv
module msr_restore
  import msr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      op_i,
  input  logic            accept_i,
  input  logic            slot_done_i,
  input  logic [XLEN-1:0] base_i,
  output logic [XLEN-1:0] msr_o
);
  ret_kind_e pend_q, new_kind;
  logic      commit;
  logic [XLEN-1:0] flagged;
  logic [XLEN-1:0] restored;

  always_comb begin
    unique case (msr_op_e'(op_i))
      OP_RET_INT: new_kind = RK_INT;
      OP_RET_BRK: new_kind = RK_BRK;
      OP_RET_EXC: new_kind = RK_EXC;
      default:    new_kind = RK_NONE;
    endcase
  end

  always_comb begin
    flagged = base_i;
    unique case (pend_q)
      RK_INT: flagged[POS_IE] = 1'b1;
      RK_BRK: flagged[POS_BIP] = 1'b0;
      RK_EXC: begin
        flagged[POS_EE]  = 1'b1;
        flagged[POS_EIP] = 1'b0;
      end
      default: ;
    endcase
  end

  // each mode bit takes its saved copy one position up
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    logic is_mode;
    always_comb begin
      is_mode = 1'b0;
      for (int unsigned k = 0; k < NUM_MODE; k++)
        if (mode_pos(k) == b) is_mode = 1'b1;
    end
    if (b + 1 < XLEN) begin : g_hi
      assign restored[b] = is_mode ? flagged[b+1] : flagged[b];
    end else begin : g_top
      assign restored[b] = flagged[b];
    end
  end

  assign commit = slot_done_i && (pend_q != RK_NONE);
  assign msr_o  = commit ? restored : base_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RK_NONE;
    end else begin
      if (accept_i && new_kind != RK_NONE) pend_q <= new_kind;
      else if (commit)                     pend_q <= RK_NONE;
    end
  end
endmodule

// File: rtl/msr_unit.sv
module msr_unit
  import msr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] operand_i,
  input  logic            user_i,
  input  logic            exc_en_i,
  input  logic            slot_done_i,
  output logic [XLEN-1:0] msr_o,
  output logic            carry_o,
  output logic            priv_fault_o
);
  logic [XLEN-1:0] msr_q, op_next, msr_d;
  logic            fault, fault_q;

  msr_priv_check #(.XLEN(XLEN)) priv_i (
    .op_i(op_i), .operand_i(operand_i), .user_i(user_i),
    .exc_en_i(exc_en_i), .fault_o(fault)
  );

  msr_op_unit #(.XLEN(XLEN)) opu_i (
    .msr_i(msr_q), .op_i(op_i), .operand_i(operand_i),
    .accept_i(!fault), .msr_o(op_next)
  );

  msr_restore #(.XLEN(XLEN)) rst_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .accept_i(!fault),
    .slot_done_i(slot_done_i), .base_i(op_next), .msr_o(msr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msr_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      msr_q   <= msr_d;
      fault_q <= fault;
    end
  end

  assign msr_o        = msr_q;
  assign carry_o      = msr_q[POS_CARRY];
  assign priv_fault_o = fault_q;
endmodule

// File: rtl/msr_unit_chk.sv
module msr_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] operand_i,
  input logic            user_i,
  input logic            exc_en_i,
  input logic            slot_done_i,
  input logic [XLEN-1:0] msr_o,
  input logic            carry_o,
  input logic            priv_fault_o
);
  AST_CARRY_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && !slot_done_i) |=> (msr_o[31] == $past(operand_i[0]) && msr_o[2] == $past(operand_i[0]) && carry_o == msr_o[31])); // R2
  AST_SET_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && !user_i && !slot_done_i) |=> (msr_o == ($past(msr_o) | $past(operand_i)))); // R3
  AST_LOAD_VER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && !(user_i && exc_en_i) && !slot_done_i) |=> msr_o[10]); // R5
  AST_RET_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 3'd5 && !slot_done_i) |=> $stable(msr_o)); // R9
  AST_FAULT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_i && exc_en_i && op_i >= 3'd4 && !slot_done_i) |=> (priv_fault_o && $stable(msr_o))); // R10
  AST_NO_FAULT_KERNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_en_i) |=> !priv_fault_o); // R11
endmodule

bind msr_unit msr_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .operand_i(operand_i),
  .user_i(user_i), .exc_en_i(exc_en_i), .slot_done_i(slot_done_i),
  .msr_o(msr_o), .carry_o(carry_o), .priv_fault_o(priv_fault_o)
);

// File: tb/msr_unit_tb_top.sv
module msr_unit_tb_top;
  localparam int unsigned XLEN = 32;
  localparam int NV = 25;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] opnd;
    logic        user;
    logic        ee;
    logic        slot;
    logic [31:0] exp;
    logic        flt;
  } vec_t;

  // op, operand, user, ee, slot, expected word, expected fault
  localparam vec_t VEC [NV] = '{
    '{3'd1, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 32'h8000_0004, 1'b0}, // R2
    '{3'd2, 32'h0000_5000, 1'b0, 1'b0, 1'b0, 32'h8000_5004, 1'b0}, // R3
    '{3'd3, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_5004, 1'b0}, // R4
    '{3'd1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_5000, 1'b0}, // R2
    '{3'd5, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_5000, 1'b0}, // R9
    '{3'd0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h0000_7802, 1'b0}, // R6
    '{3'd4, 32'h0000_0208, 1'b0, 1'b0, 1'b0, 32'h0000_0608, 1'b0}, // R5
    '{3'd6, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0608, 1'b0}, // R9
    '{3'd0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h0000_0600, 1'b0}, // R7
    '{3'd4, 32'h0000_4200, 1'b0, 1'b0, 1'b0, 32'h0000_4600, 1'b0}, // R5
    '{3'd7, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_4600, 1'b0}, // R9
    '{3'd0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h0000_6500, 1'b0}, // R8
    '{3'd2, 32'h0000_0001, 1'b1, 1'b1, 1'b0, 32'h0000_6500, 1'b1}, // R10
    '{3'd4, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0000_6500, 1'b1}, // R10
    '{3'd5, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0000_6500, 1'b1}, // R10
    '{3'd0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h0000_6500, 1'b0}, // R10 nothing armed
    '{3'd2, 32'h0000_0004, 1'b1, 1'b1, 1'b0, 32'h0000_6504, 1'b0}, // R11
    '{3'd3, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0000_6504, 1'b0}, // R11
    '{3'd3, 32'h0000_0004, 1'b1, 1'b1, 1'b0, 32'h0000_6500, 1'b0}, // R11
    '{3'd4, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 32'h0000_0401, 1'b0}, // R11
    '{3'd4, 32'h0000_5000, 1'b0, 1'b0, 1'b0, 32'h0000_5400, 1'b0}, // R5
    '{3'd5, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_5400, 1'b0}, // R9
    '{3'd3, 32'h0000_1000, 1'b0, 1'b0, 1'b1, 32'h0000_6402, 1'b0}, // R12
    '{3'd6, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_6402, 1'b0}, // R9
    '{3'd1, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 32'h8000_6406, 1'b0}  // R12
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [2:0]      op_i = '0;
  logic [XLEN-1:0] operand_i = '0;
  logic            user_i = 1'b0;
  logic            exc_en_i = 1'b0;
  logic            slot_done_i = 1'b0;
  logic [XLEN-1:0] msr_o;
  logic            carry_o;
  logic            priv_fault_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2ns clk_i = ~clk_i;

  msr_unit #(.XLEN(XLEN)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .operand_i(operand_i),
    .user_i(user_i), .exc_en_i(exc_en_i), .slot_done_i(slot_done_i),
    .msr_o(msr_o), .carry_o(carry_o), .priv_fault_o(priv_fault_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] op, logic [31:0] v, logic u, logic e, logic s);
    op_i = op; operand_i = v; user_i = u; exc_en_i = e; slot_done_i = s;
  endtask

  initial begin
    #1ns;
    chk("R1 reset word", msr_o, 32'h0);
    chk("R1 reset carry", {31'h0, carry_o}, 32'h0);
    chk("R1 reset fault", {31'h0, priv_fault_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].opnd, VEC[i].user, VEC[i].ee, VEC[i].slot);
      @(negedge clk_i);
      chk($sformatf("vec%0d word R2..R12", i), msr_o, VEC[i].exp);
      chk($sformatf("vec%0d carry R2", i), {31'h0, carry_o}, {31'h0, VEC[i].exp[31]});
      chk($sformatf("vec%0d fault R10", i), {31'h0, priv_fault_o}, {31'h0, VEC[i].flt});
    end
    // R1: reset while a return is armed discards it
    drive(3'd5, 32'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    drive(3'd0, 32'h0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b0;
    #1ns;
    chk("R1 async reset word", msr_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(3'd0, 32'h0, 1'b0, 1'b0, 1'b1);
    @(negedge clk_i);
    chk("R1 armed return dropped", msr_o, 32'h0);
    // R9: slot with nothing armed has no effect after a load of saved bits
    drive(3'd4, 32'h0000_5000, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    drive(3'd0, 32'h0, 1'b0, 1'b0, 1'b1);
    @(negedge clk_i);
    chk("R9 idle slot", msr_o, 32'h0000_5400);
    drive(3'd0, 32'h0, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule